// File: doc/BRIEF.md
# Square-Wave Interval Timer Channel

This block is one timer channel that produces a periodic square wave, typically wired to an interrupt line. Software programs a 16-bit initial count N through a byte-wide write port: two writes, low byte first. The channel advances only on a slow count-enable tick, nominally one pulse every 838 ns, so the full wave period is N ticks. An initial count of zero means 65536.

Each tick lowers a working counter by two. At every expiry the output level inverts and the working counter is reloaded from the programmed count. With an odd count the high half is one tick longer than the low half. A gate input freezes the channel and holds the output high. When the gate rises again, the wave restarts from a fresh load. A status output mirrors the wave level so it can be read back.

Top module: `sqwave_timer`

## Requirements
- R1: After reset the wave output is low and the channel does not count until a complete count has been written.
- R2: A count is written as two byte writes, low byte first. A lone low-byte write does not arm the channel, and only the high-byte write commits the 16-bit value.
- R3: A committed count is transferred into the working counter on the first tick after the write, not on the write itself. From that tick the wave is high.
- R4: For an even count N the wave stays high for N/2 ticks and then low for N/2 ticks, repeating, because the counter falls by two per tick.
- R5: For an odd count N of 3 or more the high half lasts (N+1)/2 ticks and the low half (N-1)/2 ticks. An extra count is taken on the first tick of each low half.
- R6: A programmed count of zero behaves as 65536, giving halves of 32768 ticks.
- R7: Clock cycles without a tick leave the wave level unchanged.
- R8: While the gate is low the wave is high from the next clock and ticks have no effect. After the gate rises, the next tick reloads the count and starts a full high half.
- R9: A count written while the wave is running leaves the current half unchanged and is used from the next expiry onward.
- R10: The status output always equals the wave output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-enable pulse, one clock wide |
| wr_en | input | 1 | Byte write strobe for the count |
| wr_data | input | 8 | Count byte, low byte first then high byte |
| gate | input | 1 | High lets the channel count, low freezes it |
| wave_o | output | 1 | Square-wave / interrupt level |
| status_o | output | 1 | Read-back copy of the wave level |

## Verification
Every result is one register away from its cause:
- The wave changes at the clock edge that samples an enabled tick.
- A high-byte write commits at its own edge, so the count is only usable by a tick in a later cycle.
- A low gate forces the wave high at the very next edge.

The bench drives inputs on falling edges and samples one falling edge after the rising edge that acts on them. It measures half-periods by counting the ticks it applies until the level flips. This ties each expected length directly to a tick count.

// File: rtl/pit_pkg.sv
// Package: shared definitions for the square-wave timer channel.
// Assumes the count width is a whole multiple of the byte width.
package pit_pkg;
    // Byte width of the software write port.
    localparam int PIT_BYTE_W = 8;
    // Amount removed from the working counter on an ordinary tick.
    localparam int PIT_STEP = 2;
endpackage

// File: rtl/pit_count_loader.sv
// Module: assembles the programmed count from byte writes, low byte first.
// Only the final (most significant) byte commits the full value and raises
// the valid flag. Lower bytes are staged and are not visible before commit.
// Assumes CNT_W / BYTE_W >= 2.
module pit_count_loader #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = pit_pkg::PIT_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count_o,
    output logic              valid_o
);
    localparam int NB = CNT_W / BYTE_W;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;
    localparam int LOW_W = CNT_W - BYTE_W;

    logic [IW-1:0]    idx_q;
    logic [LOW_W-1:0] stage_q;
    logic             last_byte;

    assign last_byte = (idx_q == IW'(NB - 1));

    // Byte pointer: steps on every write and wraps after the top byte.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx_q <= '0;
        else if (wr_en)      idx_q <= last_byte ? '0 : idx_q + IW'(1);
    end

    // Staging of the lower bytes, one register slice per byte position.
    for (genvar b = 0; b < NB - 1; b++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)                               stage_q[b*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && idx_q == IW'(b))        stage_q[b*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    // Commit: the top byte plus the staged bytes become the programmed count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            valid_o <= 1'b0;
        end else if (wr_en && last_byte) begin
            count_o <= {wr_data, stage_q};
            valid_o <= 1'b1;
        end
    end

    // R2: the top byte write arms the channel.
    p_commit_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && last_byte) |=> valid_o);
    // R2: no write of the top byte means the committed count holds.
    p_count_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && last_byte) |=> $stable(count_o));
endmodule

// File: rtl/pit_sq_core.sv
// Module: square-wave counting engine. On an enabled tick it either loads
// the programmed count (first tick after arming or after the gate rises) or
// removes two from the working counter. At expiry it flips the wave and
// reloads. For an odd count one extra unit is taken on the first tick of
// each low half. A zero count is widened to 2**CNT_W.
// Assumes tick is one clock wide.
module pit_sq_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             valid,
    input  logic [CNT_W-1:0] count,
    output logic             wave_o
);
    localparam int RW = CNT_W + 1;
    localparam logic [RW-1:0] FULL = RW'(1) << CNT_W;

    logic [RW-1:0] cnt_q;
    logic          run_q;
    logic          odd_q;
    logic          first_q;
    logic          out_q;
    logic [RW-1:0] reload_val;
    logic [RW-1:0] dec;
    logic          expire;

    // Reload value: zero stands for the full range.
    assign reload_val = (count == '0) ? FULL : {1'b0, count};

    // Step size: the extra unit is taken on the first tick of an odd low half.
    assign dec    = RW'(pit_pkg::PIT_STEP) + RW'(first_q && odd_q && !out_q);
    assign expire = (cnt_q <= dec);

    // Counter, phase and wave state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            run_q   <= 1'b0;
            odd_q   <= 1'b0;
            first_q <= 1'b0;
            out_q   <= 1'b0;
        end else if (!gate) begin
            run_q <= 1'b0;
            out_q <= 1'b1;
        end else if (tick) begin
            if (!run_q) begin
                if (valid) begin
                    cnt_q   <= reload_val;
                    odd_q   <= count[0];
                    first_q <= 1'b1;
                    out_q   <= 1'b1;
                    run_q   <= 1'b1;
                end
            end else if (expire) begin
                cnt_q   <= reload_val;
                odd_q   <= count[0];
                first_q <= 1'b1;
                out_q   <= !out_q;
            end else begin
                cnt_q   <= cnt_q - dec;
                first_q <= 1'b0;
            end
        end
    end

    assign wave_o = out_q;

    // R8: a low gate forces the wave high on the next clock.
    p_gate_forces_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> out_q);
    // R7: with the gate open and no tick, the wave keeps its level.
    p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !tick) |=> $stable(out_q));
    // R6: a running counter stays within 1..2**CNT_W.
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q != '0 && cnt_q <= FULL));
    // R3: starting to run always begins with the wave high.
    p_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> out_q);
    // R1: the channel cannot start before a count was committed.
    p_no_start_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> !$rose(run_q));
endmodule

// File: rtl/sqwave_timer.sv
// Module: top of the square-wave timer channel. Joins the byte-write count
// loader to the counting engine and exposes the wave and its status copy.
// Assumes synchronous active-low reset and a one-clock-wide tick.
module sqwave_timer #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = pit_pkg::PIT_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              gate,
    output logic              wave_o,
    output logic              status_o
);
    logic [CNT_W-1:0] prog_count;
    logic             prog_valid;
    logic             wave_int;

    pit_count_loader #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .count_o (prog_count),
        .valid_o (prog_valid)
    );

    pit_sq_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .gate   (gate),
        .valid  (prog_valid),
        .count  (prog_count),
        .wave_o (wave_int)
    );

    // R10: the status bit is the wave level itself.
    assign wave_o   = wave_int;
    assign status_o = wave_int;
endmodule

// File: tb/tb_sqwave_timer.sv
module tb_sqwave_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       gate = 1'b1;
    logic       wave_o;
    logic       status_o;

    int total = 0;
    int bad = 0;
    int stat_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sqwave_timer dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .gate(gate), .wave_o(wave_o), .status_o(status_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            finish_up();
        end
    end

    // R10 monitor: compare status with the wave away from the edge.
    always @(negedge clk) if (rst_n && status_o !== wave_o) stat_bad++;

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wr_count(input logic [15:0] n);
        wr_byte(n[7:0]);
        wr_byte(n[15:8]);
    endtask

    task automatic one_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    // Counts the ticks applied until the wave leaves the given level.
    task automatic measure(input logic lvl, output int len);
        len = 0;
        tick = 1'b1;
        do begin
            @(negedge clk);
            len++;
        end while (wave_o == lvl && len < 70000);
        tick = 1'b0;
    endtask

    // Restarts the channel with a new count through the gate.
    task automatic restart(input logic [15:0] n, input string req);
        @(negedge clk); gate = 1'b0;
        wr_count(n);
        @(negedge clk); gate = 1'b1;
        one_tick();
        check(req, wave_o, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset level", wave_o, 0);
        tick = 1'b1;
        repeat (4) @(negedge clk);
        tick = 1'b0;
        check("R1 no count before write", wave_o, 0);
    endtask

    task automatic t_partial();
        wr_byte(8'h04);
        tick = 1'b1;
        repeat (4) @(negedge clk);
        tick = 1'b0;
        check("R2 low byte alone does not arm", wave_o, 0);
    endtask

    task automatic t_load_delay();
        int len;
        wr_byte(8'h00);
        repeat (3) @(negedge clk);
        check("R3 no load without tick", wave_o, 0);
        one_tick();
        check("R3 high after load tick", wave_o, 1);
        measure(1'b1, len);
        check("R2 count 4 assembled, high half", len, 2);
    endtask

    task automatic t_even();
        int len;
        restart(16'd6, "R4 restart");
        measure(1'b1, len); check("R4 even high half", len, 3);
        measure(1'b0, len); check("R4 even low half", len, 3);
        measure(1'b1, len); check("R4 even second high", len, 3);
    endtask

    task automatic t_odd();
        int len;
        restart(16'd7, "R5 restart");
        measure(1'b1, len); check("R5 odd high half", len, 4);
        measure(1'b0, len); check("R5 odd low half", len, 3);
        measure(1'b1, len); check("R5 odd second high", len, 4);
    endtask

    task automatic t_no_tick();
        restart(16'd2, "R7 restart");
        repeat (8) @(negedge clk);
        check("R7 level held without tick", wave_o, 1);
        one_tick();
        check("R7 flips on tick", wave_o, 0);
    endtask

    task automatic t_midrun();
        int len;
        restart(16'd4, "R9 restart");
        one_tick();
        wr_count(16'd8);
        measure(1'b1, len); check("R9 current half kept", len, 1);
        measure(1'b0, len); check("R9 new low half", len, 4);
        measure(1'b1, len); check("R9 new high half", len, 4);
    endtask

    task automatic t_gate();
        int len;
        restart(16'd6, "R8 restart");
        measure(1'b1, len);
        one_tick();
        check("R8 in low half", wave_o, 0);
        @(negedge clk); gate = 1'b0;
        @(negedge clk);
        check("R8 gate low forces high", wave_o, 1);
        tick = 1'b1;
        repeat (5) @(negedge clk);
        tick = 1'b0;
        check("R8 ticks ignored while gated", wave_o, 1);
        gate = 1'b1;
        repeat (2) @(negedge clk);
        one_tick();
        check("R8 reload high", wave_o, 1);
        measure(1'b1, len); check("R8 full high half after gate", len, 3);
    endtask

    task automatic t_zero();
        int len;
        restart(16'd0, "R6 restart");
        measure(1'b1, len); check("R6 zero count high half", len, 32768);
    endtask

    initial begin
        t_reset();
        t_partial();
        t_load_delay();
        t_even();
        t_odd();
        t_no_tick();
        t_midrun();
        t_gate();
        t_zero();
        check("R10 status equals wave", stat_bad, 0);
        finish_up();
    end
endmodule